// File: doc/BRIEF.md
# Expansion Bus Bridge, 16-bit Host to 32-bit Memory Bus

This block sits between a 16-bit processor bus and an expansion memory bus that carries 32 data lines and 20 address lines. It decodes three control ports in the processor's I/O space. Port 0 drives three indicator LEDs. Port 2 holds the expansion page bits, a 32-bit assembly mode bit and an off-board routing bit. Port 4 chooses whether the on-board memory window is served by SRAM or by FLASH. The low fifteen expansion address lines follow the processor address bus. The upper lines come from the page field.

Data-space accesses at 0x8000 and above fall in the external window. Each such access raises exactly one chip select: the expansion select when off-board routing is set, and otherwise FLASH or SRAM as port 4 chooses. After reset the window is served by FLASH. Writing zero to ports 0, 2 and 4 moves it to SRAM.

In 16-bit mode each expansion write replaces the low half of the 32 data lines. In 32-bit mode the upper half is written first, to an odd address, and is held in a staging register. The following write to an even address drives both halves together. In both modes the data lines keep the last committed word until the next commit. This lets the lines act as a parallel output latch.

Top module: `xbus_bridge`

## Requirements
- R1: After reset, LEDs read 0, the port 2 fields are all 0, port 4 bit 0 is 1 (FLASH), the expansion data lines are 0 and the expansion write strobe is low.
- R2: An I/O write to port 0 sets the LEDs to bits 2:0 of the written data. Port 0 reads back the LED state in bits 2:0 and zero elsewhere.
- R3: Port 2 holds the page in bits 4:0, the 32-bit mode flag in bit 6 and the off-board flag in bit 7. It reads back those bits, and every other bit reads as 0.
- R4: The expansion address equals {page, processor address bits 14:0}.
- R5: A data-space read or write with address bit 15 set raises exactly one select. It raises the expansion select when off-board is set, the FLASH select when off-board is clear and port 4 bit 0 is 1, and the SRAM select otherwise. I/O accesses, idle cycles and addresses below 0x8000 raise no select.
- R6: Port 4 bit 0 chooses FLASH (1) or SRAM (0) and reads back in bit 0. Writing 0 to ports 0, 2 and 4 leaves the window on SRAM with the LEDs off.
- R7: In 16-bit mode, an expansion write replaces data bits 15:0 and keeps bits 31:16. The new word and a one-cycle write strobe appear in the cycle after the write.
- R8: In 32-bit mode, an expansion write to an odd address (bit 0 = 1) only stages the upper half: the data lines stay the same and no strobe is raised. The next write to an even address drives {staged, written} and raises the strobe one cycle later.
- R9: The expansion data lines hold their value through reads, I/O writes and writes that do not reach the expansion bus.
- R10: I/O reads return data in the same cycle. Ports other than 0, 2 and 4 read as 0.
- R11: Writes below 0x8000, and writes in the window while off-board is clear, leave the expansion data lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | 1 for an I/O-space access, 0 for data space |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_addr | input | 16 | Processor address or port number |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Port read data, combinational |
| led | output | 3 | Indicator outputs |
| xb_addr | output | 20 | Expansion address |
| xb_wdata | output | 32 | Latched expansion data |
| xb_we | output | 1 | One-cycle pulse marking a new word on xb_wdata |
| sram_cs | output | 1 | On-board SRAM select |
| flash_cs | output | 1 | On-board FLASH select |
| xb_cs | output | 1 | Expansion bus select |

## Verification
Two events can land on the same clock cycle. One is the registered commit of a 32-bit word, which shows up as the strobe and the new data. The other is the combinational decode of the next access. The bench provokes this by issuing back-to-back accesses: a control port write that changes page or mode follows straight after an even-address commit, and a read of the window follows a write. It judges the result in two ways. A scoreboard pairs every strobe with the word predicted from the mode in force when the write was issued. Separate checks confirm that the later control write neither disturbs that word nor raises a stray strobe.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
   typedef struct packed {
      logic offboard;
      logic wide;
      logic flash_sel;
   } ctl_t;

   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_SRAM  = 2'd1,
      TGT_FLASH = 2'd2,
      TGT_XBUS  = 2'd3
   } tgt_e;
endpackage

// File: rtl/xbb_ioregs.sv
module xbb_ioregs
   import xbb_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int LED_N     = 3,
   parameter int PAGE_W    = 5,
   parameter int LED_PORT  = 0,
   parameter int CTL_PORT  = 2,
   parameter int MSEL_PORT = 4,
   parameter int WIDE_BIT  = 6,
   parameter int OFF_BIT   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [AW-1:0]     port,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic [LED_N-1:0]  led,
   output logic [PAGE_W-1:0] page,
   output ctl_t              ctl
);
   localparam logic [AW-1:0] LED_A  = AW'(LED_PORT);
   localparam logic [AW-1:0] CTL_A  = AW'(CTL_PORT);
   localparam logic [AW-1:0] MSEL_A = AW'(MSEL_PORT);

   if (PAGE_W > WIDE_BIT || WIDE_BIT >= OFF_BIT || OFF_BIT >= DW) begin : g_bad_fields
      $error("xbb_ioregs: control fields overlap or exceed the data width");
   end
   if (LED_N > DW || LED_N < 1) begin : g_bad_led
      $error("xbb_ioregs: LED count out of range");
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         led           <= '0;
         page          <= '0;
         ctl.offboard  <= 1'b0;
         ctl.wide      <= 1'b0;
         ctl.flash_sel <= 1'b1;
      end else if (io_wr) begin
         if (port == LED_A) begin
            led <= wdata[LED_N-1:0];
         end
         if (port == CTL_A) begin
            page         <= wdata[PAGE_W-1:0];
            ctl.wide     <= wdata[WIDE_BIT];
            ctl.offboard <= wdata[OFF_BIT];
         end
         if (port == MSEL_A) begin
            ctl.flash_sel <= wdata[0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (io_rd) begin
         if (port == LED_A) begin
            rdata[LED_N-1:0] = led;
         end else if (port == CTL_A) begin
            rdata[PAGE_W-1:0] = page;
            rdata[WIDE_BIT]   = ctl.wide;
            rdata[OFF_BIT]    = ctl.offboard;
         end else if (port == MSEL_A) begin
            rdata[0] = ctl.flash_sel;
         end
      end
   end
endmodule

// File: rtl/xbb_decode.sv
module xbb_decode
   import xbb_pkg::*;
(
   input  logic mem_acc,
   input  logic addr_hi,
   input  ctl_t ctl,
   output tgt_e tgt,
   output logic sram_cs,
   output logic flash_cs,
   output logic xb_cs
);
   always_comb begin
      tgt = TGT_NONE;
      if (mem_acc && addr_hi) begin
         if (ctl.offboard)       tgt = TGT_XBUS;
         else if (ctl.flash_sel) tgt = TGT_FLASH;
         else                    tgt = TGT_SRAM;
      end
   end

   assign sram_cs  = (tgt == TGT_SRAM);
   assign flash_cs = (tgt == TGT_FLASH);
   assign xb_cs    = (tgt == TGT_XBUS);
endmodule

// File: rtl/xbb_datalatch.sv
module xbb_datalatch #(
   parameter int DW         = 16,
   parameter int XDW        = 32,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic           odd,
   input  logic           wide,
   input  logic [DW-1:0]  wdata,
   output logic [XDW-1:0] xb_wdata,
   output logic           xb_we
);
   if (XDW != 2 * DW) begin : g_bad_width
      $error("xbb_datalatch: expansion width must be twice the host width");
   end

   logic [DW-1:0] hi_next;
   logic          commit;

   if (ALLOW_WIDE) begin : g_wide
      logic [DW-1:0] stage_q;
      logic          use_stage;

      assign use_stage = wide;
      assign commit    = wr && !(wide && odd);
      assign hi_next   = use_stage ? stage_q : xb_wdata[XDW-1:DW];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q <= '0;
         end else if (wr && wide && odd) begin
            stage_q <= wdata;
         end
      end
   end else begin : g_narrow
      logic unused_mode;
      assign unused_mode = ^{wide, odd};
      assign commit      = wr;
      assign hi_next     = xb_wdata[XDW-1:DW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xb_wdata <= '0;
         xb_we    <= 1'b0;
      end else begin
         xb_we <= commit;
         if (commit) begin
            xb_wdata <= {hi_next, wdata};
         end
      end
   end
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
   import xbb_pkg::*;
#(
   parameter int CPU_AW     = 16,
   parameter int CPU_DW     = 16,
   parameter int XB_AW      = 20,
   parameter int XB_DW      = 32,
   parameter int LED_N      = 3,
   parameter bit ALLOW_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [CPU_DW-1:0] cpu_wdata,
   output logic [CPU_DW-1:0] cpu_rdata,
   output logic [LED_N-1:0]  led,
   output logic [XB_AW-1:0]  xb_addr,
   output logic [XB_DW-1:0]  xb_wdata,
   output logic              xb_we,
   output logic              sram_cs,
   output logic              flash_cs,
   output logic              xb_cs
);
   localparam int XB_LOW_W = CPU_AW - 1;
   localparam int PAGE_W   = XB_AW - XB_LOW_W;

   if (PAGE_W < 1) begin : g_bad_aw
      $error("xbus_bridge: expansion address must be wider than the host window");
   end
   if (CPU_AW < 2) begin : g_bad_cpu_aw
      $error("xbus_bridge: host address too narrow");
   end

   ctl_t              ctl_q;
   tgt_e              tgt;
   logic [PAGE_W-1:0] page_q;
   logic              mem_acc;
   logic              io_wr;
   logic              io_rd;

   assign mem_acc = !io_sel && (cpu_wr || cpu_rd);
   assign io_wr   = io_sel && cpu_wr;
   assign io_rd   = io_sel && cpu_rd;

   xbb_ioregs #(
      .AW     (CPU_AW),
      .DW     (CPU_DW),
      .LED_N  (LED_N),
      .PAGE_W (PAGE_W)
   ) i_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .io_wr (io_wr),
      .io_rd (io_rd),
      .port  (cpu_addr),
      .wdata (cpu_wdata),
      .rdata (cpu_rdata),
      .led   (led),
      .page  (page_q),
      .ctl   (ctl_q)
   );

   xbb_decode i_dec (
      .mem_acc  (mem_acc),
      .addr_hi  (cpu_addr[CPU_AW-1]),
      .ctl      (ctl_q),
      .tgt      (tgt),
      .sram_cs  (sram_cs),
      .flash_cs (flash_cs),
      .xb_cs    (xb_cs)
   );

   logic unused_tgt;
   assign unused_tgt = ^tgt;

   xbb_datalatch #(
      .DW         (CPU_DW),
      .XDW        (XB_DW),
      .ALLOW_WIDE (ALLOW_WIDE)
   ) i_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (xb_cs && cpu_wr),
      .odd      (cpu_addr[0]),
      .wide     (ctl_q.wide),
      .wdata    (cpu_wdata),
      .xb_wdata (xb_wdata),
      .xb_we    (xb_we)
   );

   assign xb_addr = {page_q, cpu_addr[XB_LOW_W-1:0]};
endmodule

// File: rtl/xbb_checker.sv
module xbb_checker #(
   parameter int CPU_AW = 16,
   parameter int CPU_DW = 16,
   parameter int XB_DW  = 32,
   parameter int LED_N  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              io_sel,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic [CPU_DW-1:0] cpu_wdata,
   input logic [LED_N-1:0]  led,
   input logic [XB_DW-1:0]  xb_wdata,
   input logic              xb_we,
   input logic              sram_cs,
   input logic              flash_cs,
   input logic              xb_cs,
   input logic              wide,
   input logic              offboard
);
   // R5: never two selects together
   a_r5_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sram_cs, flash_cs, xb_cs}));

   // R5: no select outside a data-space window access
   a_r5_cs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel || !(cpu_wr || cpu_rd) || !cpu_addr[CPU_AW-1]) |-> !(sram_cs || flash_cs || xb_cs));

   // R5: off-board routing wins inside the window
   a_r5_offboard_route: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_sel && (cpu_wr || cpu_rd) && cpu_addr[CPU_AW-1] && offboard) |-> xb_cs);

   // R9: data lines only move together with the strobe
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xb_we |-> $stable(xb_wdata));

   // R7: every strobe is caused by an expansion write one cycle earlier
   a_r7_we_cause: assert property (@(posedge clk) disable iff (!rst_n)
      xb_we |-> $past(xb_cs && cpu_wr));

   // R8: an odd write in 32-bit mode raises no strobe
   a_r8_odd_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (xb_cs && cpu_wr && wide && cpu_addr[0]) |=> !xb_we);

   // R2: LED port write shows up on the outputs next cycle
   a_r2_led: assert property (@(posedge clk) disable iff (!rst_n)
      (io_sel && cpu_wr && cpu_addr == '0) |=> (led == $past(cpu_wdata[LED_N-1:0])));
endmodule

bind xbus_bridge xbb_checker #(
   .CPU_AW (CPU_AW),
   .CPU_DW (CPU_DW),
   .XB_DW  (XB_DW),
   .LED_N  (LED_N)
) i_xbb_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_sel    (io_sel),
   .cpu_wr    (cpu_wr),
   .cpu_rd    (cpu_rd),
   .cpu_addr  (cpu_addr),
   .cpu_wdata (cpu_wdata),
   .led       (led),
   .xb_wdata  (xb_wdata),
   .xb_we     (xb_we),
   .sram_cs   (sram_cs),
   .flash_cs  (flash_cs),
   .xb_cs     (xb_cs),
   .wide      (ctl_q.wide),
   .offboard  (ctl_q.offboard)
);

// File: tb/test_xbus_bridge.sv
module test_xbus_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_sel = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic [2:0]  led;
   logic [19:0] xb_addr;
   logic [31:0] xb_wdata;
   logic        xb_we;
   logic        sram_cs, flash_cs, xb_cs;

   int checks = 0;
   int failures = 0;

   logic [31:0] exp_q[$];
   logic        m_off = 1'b0;
   logic        m_wide = 1'b0;
   logic        m_flash = 1'b1;
   logic [15:0] m_stage = '0;
   logic [31:0] m_word = '0;

   always #10 clk = ~clk;

   xbus_bridge i_xbus_bridge (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .led(led),
      .xb_addr(xb_addr), .xb_wdata(xb_wdata), .xb_we(xb_we),
      .sram_cs(sram_cs), .flash_cs(flash_cs), .xb_cs(xb_cs)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every strobe must match the oldest predicted word
   always @(negedge clk) begin
      if (rst_n && xb_we) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7/R8 unexpected strobe", xb_wdata, 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(xb_wdata == e, "R7/R8 committed word", xb_wdata, e);
         end
      end
   end

   task automatic io_write(input logic [15:0] port, input logic [15:0] d);
      @(negedge clk);
      io_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = port; cpu_wdata = d;
      if (port == 16'd2) begin m_off = d[7]; m_wide = d[6]; end
      if (port == 16'd4) m_flash = d[0];
      @(negedge clk);
      cpu_wr = 1'b0; io_sel = 1'b0;
   endtask

   task automatic io_read(input logic [15:0] port, input logic [15:0] exp, input string tag);
      @(negedge clk);
      io_sel = 1'b1; cpu_rd = 1'b1; cpu_addr = port;
      #2;
      chk(cpu_rdata == exp, tag, {16'h0, cpu_rdata}, {16'h0, exp});
      @(negedge clk);
      cpu_rd = 1'b0; io_sel = 1'b0;
   endtask

   task automatic mem_acc(input bit wr, input logic [15:0] a, input logic [15:0] d);
      logic [2:0] exp_cs;
      @(negedge clk);
      io_sel = 1'b0; cpu_wr = wr; cpu_rd = !wr; cpu_addr = a; cpu_wdata = d;
      exp_cs = !a[15] ? 3'b000 : m_off ? 3'b001 : m_flash ? 3'b010 : 3'b100;
      if (wr && a[15] && m_off) begin
         if (m_wide && a[0]) begin
            m_stage = d;
         end else begin
            m_word = m_wide ? {m_stage, d} : {m_word[31:16], d};
            exp_q.push_back(m_word);
         end
      end
      #2;
      chk({sram_cs, flash_cs, xb_cs} == exp_cs, "R5 chip selects", {29'h0, sram_cs, flash_cs, xb_cs}, {29'h0, exp_cs});
      @(negedge clk);
      cpu_wr = 1'b0; cpu_rd = 1'b0;
      #1;
      chk(xb_wdata == m_word, "R9 latched data after access", xb_wdata, m_word);
   endtask

   initial begin
      #(20 * 200000);
      chk(1'b0, "watchdog expired", 32'h0, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(led == 3'b000, "R1 led", {29'h0, led}, 32'h0);
      chk(xb_wdata == 32'h0, "R1 data", xb_wdata, 32'h0);
      chk(xb_we == 1'b0, "R1 strobe", {31'h0, xb_we}, 32'h0);
      io_read(16'd0, 16'h0000, "R1 port0");
      io_read(16'd2, 16'h0000, "R1 port2");
      io_read(16'd4, 16'h0001, "R1 port4 FLASH");
      // R10 unmapped ports
      io_read(16'd1, 16'h0000, "R10 port1");
      io_read(16'd3, 16'h0000, "R10 port3");
      io_read(16'h00FF, 16'h0000, "R10 port 0xFF");
      // R5/R6 FLASH after reset, nothing below window
      mem_acc(1'b0, 16'h8000, 16'h0);
      mem_acc(1'b0, 16'h1234, 16'h0);
      // R2 LEDs
      io_write(16'd0, 16'h0007);
      #1 chk(led == 3'b111, "R2 led all on", {29'h0, led}, 32'h7);
      io_read(16'd0, 16'h0007, "R2 port0 readback");
      io_write(16'd0, 16'hFFFA);
      #1 chk(led == 3'b010, "R2 led low bits only", {29'h0, led}, 32'h2);
      // R6 SRAM select
      io_write(16'd4, 16'h0000);
      mem_acc(1'b0, 16'h9000, 16'h0);
      io_read(16'd4, 16'h0000, "R6 port4 SRAM");
      // R3 field readback and R4 address
      io_write(16'd2, 16'hFFFF);
      io_read(16'd2, 16'h00DF, "R3 port2 readback");
      @(negedge clk);
      cpu_addr = 16'h8ABC;
      #1 chk(xb_addr == 20'hF8ABC, "R4 address page 1F", {12'h0, xb_addr}, 32'hF8ABC);
      io_write(16'd2, 16'h0083);
      @(negedge clk);
      cpu_addr = 16'h0123;
      #1 chk(xb_addr == 20'h18123, "R4 address page 3", {12'h0, xb_addr}, 32'h18123);
      // R7 16-bit mode
      mem_acc(1'b1, 16'h8002, 16'h1111);
      mem_acc(1'b1, 16'h8003, 16'h2222);
      // R11 writes that miss the expansion bus
      mem_acc(1'b1, 16'h0100, 16'h5555);
      io_write(16'd0, 16'h0001);
      #1 chk(xb_wdata == m_word, "R11 io write keeps data", xb_wdata, m_word);
      // R8 32-bit mode
      io_write(16'd2, 16'h00C0);
      mem_acc(1'b1, 16'hC001, 16'hABCD);
      chk(xb_we == 1'b0, "R8 odd write no strobe", {31'h0, xb_we}, 32'h0);
      mem_acc(1'b1, 16'hC000, 16'h1234);
      chk(xb_wdata == 32'hABCD1234, "R8 pair assembled", xb_wdata, 32'hABCD1234);
      // same-cycle: control write right after a commit
      mem_acc(1'b1, 16'h8005, 16'hDEAD);
      mem_acc(1'b1, 16'h8004, 16'hBEEF);
      io_write(16'd2, 16'h0080);
      #1 chk(xb_wdata == 32'hDEADBEEF, "R9 data kept over control write", xb_wdata, 32'hDEADBEEF);
      // R9 read in window keeps data
      mem_acc(1'b0, 16'hC000, 16'h0);
      // back to 16-bit: only low half moves
      mem_acc(1'b1, 16'h8006, 16'h0F0F);
      chk(xb_wdata == 32'hDEAD0F0F, "R7 low half only", xb_wdata, 32'hDEAD0F0F);
      // R11 on-board write in window
      io_write(16'd2, 16'h0000);
      mem_acc(1'b1, 16'h8008, 16'h7777);
      // R6 zero to ports 0, 2, 4 returns to SRAM
      io_write(16'd4, 16'h0001);
      io_write(16'd0, 16'h0000);
      io_write(16'd2, 16'h0000);
      io_write(16'd4, 16'h0000);
      #1 chk(led == 3'b000, "R6 leds off", {29'h0, led}, 32'h0);
      mem_acc(1'b0, 16'hFFFF, 16'h0);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R7 all predicted words seen", exp_q.size(), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule